// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Emulator

This block behaves, at its pins, like a 16K-word by 1-bit dynamic memory whose 14-bit word address arrives in two 7-bit halves over one shared address bus. Three active-low controls steer it: a row strobe, a column strobe and a write enable. A fast system clock samples them, so all timing is counted in clock cycles. The block can stand in for such a memory on a board-level or system model. A memory controller under test can then run reads, early writes, read-modify-write, page-mode bursts, row-only refresh and hidden refresh against it.

Storage is held as one word per row, each word as wide as a row, so one row is read and restored as a unit. The data output is a value plus an enable: a low enable stands for the high-impedance state. Only the column strobe opens and closes the output, so the row strobe can be cycled under a held output. A flag records a column strobe that falls while the row strobe is high.

Top module: `dram_emu`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), dout_en is 0 and order_err is 0. Stored data survives a reset.
- R2: A column strobe fall with we_n already low is an early write: din is stored at the latched row and column, and dout_en stays 0 for the whole cycle.
- R3: A column strobe fall with we_n high and the row strobe low is a read: within four clock cycles dout_en is 1 and dout equals the stored bit. Both hold while cas_n stays low.
- R4: Whenever cas_n is high, dout_en returns to 0 within four clock cycles.
- R5: A write changes only the addressed bit. Every other bit of the same row and of every other row keeps its value.
- R6: A row-strobe cycle with cas_n held high (row-only refresh) changes no stored bit and leaves dout_en at 0.
- R7: With ras_n held low, successive column strobe cycles read or write different columns of the one latched row (page mode).
- R8: With cas_n held low after a read, ras_n may be raised and lowered again with new row addresses while dout and dout_en (1) stay unchanged (hidden refresh).
- R9: If we_n falls while a read holds the output, din is written to the word being read, and dout keeps showing the old bit until cas_n rises (read-modify-write).
- R10: A column strobe fall while ras_n is high performs no read or write, leaves dout_en at 0, and sets order_err to 1. The flag stays set until reset.
- R11: The row half is taken from addr at the ras_n fall and the column half from addr at the cas_n fall. Word (r, c) and word (c, r) are distinct cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (7) | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, meaningful when dout_en is 1 |
| dout_en | output | 1 | Output drive enable; 0 stands for high impedance |
| order_err | output | 1 | Sticky flag: column strobe fell with row strobe high |

## Verification
The hardest state to reach from the ports is a held read output that has to survive both a change of the row latch and a late write. Hidden refresh and read-modify-write both need the column strobe kept low while other strobes move underneath it. The stimulus opens a read, holds cas_n low, and then either toggles ras_n several times with new row addresses or drops we_n with inverted data. It checks dout after each move and reads the whole row back afterwards. Whole-row page sweeps over rows at both address extremes, with an asymmetric bit pattern, confirm that row and column halves are not swapped.

// File: rtl/dram_emu_pkg.sv
// Shared constants and types for the dynamic memory emulator.
// Assumes strobes are active-low and sampled by a single system clock.
package dram_emu_pkg;

    // Depth of the input synchronizer chain.
    localparam int SYNC_STAGES = 2;

    // Bit positions of the strobe bundle.
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_WE  = 2;
    localparam int STB_W   = 3;

    // Access state opened by a column strobe fall.
    typedef enum logic [1:0] {
        ACC_IDLE     = 2'd0,
        ACC_READ     = 2'd1,
        ACC_EARLY_WR = 2'd2,
        ACC_RMW_DONE = 2'd3
    } acc_mode_e;

endpackage

// File: rtl/dram_sync.sv
// Multi-stage synchronizer for an asynchronous input vector.
// Assumes the vector's bits may change at any time; all bits share the delay.
module dram_sync
    import dram_emu_pkg::*;
#(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [SYNC_STAGES];

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= RST_VAL;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                // Shift through the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[i] <= RST_VAL;
                    else        stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[SYNC_STAGES-1];

endmodule

// File: rtl/dram_edge.sv
// Falling-edge detector on synchronized active-low levels.
// Assumes the input is already synchronous to clk.
module dram_edge #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev;

    // Remember the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign fall = prev & ~lvl;

endmodule

// File: rtl/dram_array.sv
// Row-organised storage: one entry per row, each entry one full row wide.
// A refresh strobe restores a whole row; a write strobe updates one bit.
// Assumes at most one bit write per cycle; contents are not reset.
module dram_array #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_row,
    input  logic [ADDR_W-1:0] rd_col,
    output logic              rd_bit,
    input  logic              ref_en,
    input  logic [ADDR_W-1:0] ref_row,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_row,
    input  logic [ADDR_W-1:0] wr_col,
    input  logic              wr_bit
);

    localparam int ROWS = 1 << ADDR_W;
    localparam int COLS = 1 << ADDR_W;

    logic [COLS-1:0] rows [ROWS];

    // Restore the refreshed row, then apply the single-bit write on top.
    always_ff @(posedge clk) begin
        if (ref_en) rows[ref_row] <= rows[ref_row];
        if (wr_en)  rows[wr_row][wr_col] <= wr_bit;
    end

    assign rd_bit = rows[rd_row][rd_col];

endmodule

// File: rtl/dram_ctrl.sv
// Strobe sequencer: latches row and column halves, decides read, early write
// or read-modify-write, and governs the output from the column strobe alone.
// Assumes synchronized inputs; strobe levels are raw active-low values.
module dram_ctrl
    import dram_emu_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_s,
    input  logic              cas_s,
    input  logic              we_s,
    input  logic              ras_fall,
    input  logic              cas_fall,
    input  logic              we_fall,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic              din_s,
    input  logic              rd_bit,
    output logic [ADDR_W-1:0] rd_row,
    output logic [ADDR_W-1:0] rd_col,
    output logic              ref_en,
    output logic [ADDR_W-1:0] ref_row,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_row,
    output logic [ADDR_W-1:0] wr_col,
    output logic              wr_bit,
    output logic              dout,
    output logic              dout_en,
    output logic              order_err
);

    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] acc_row;
    logic [ADDR_W-1:0] acc_col;
    acc_mode_e         mode;
    logic              legal;
    logic              early_wr;
    logic              late_wr;

    // Row strobe must already have been low on the previous sample.
    assign legal    = !ras_s && !ras_fall;
    assign early_wr = cas_fall && legal && !we_s;
    assign late_wr  = !cas_s && !cas_fall && (mode == ACC_READ) && we_fall && !ras_s;

    // Array addressing: reads use the live column half at the strobe fall.
    assign rd_row  = row_q;
    assign rd_col  = addr_s;
    assign ref_en  = ras_fall;
    assign ref_row = addr_s;
    assign wr_en   = early_wr || late_wr;
    assign wr_row  = cas_fall ? row_q  : acc_row;
    assign wr_col  = cas_fall ? addr_s : acc_col;
    assign wr_bit  = din_s;

    // Row latch, access latch, output register and ordering flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q     <= '0;
            acc_row   <= '0;
            acc_col   <= '0;
            mode      <= ACC_IDLE;
            dout      <= 1'b0;
            dout_en   <= 1'b0;
            order_err <= 1'b0;
        end else begin
            if (ras_fall) row_q <= addr_s;
            if (cas_s) begin
                dout_en <= 1'b0;
                mode    <= ACC_IDLE;
            end else if (cas_fall) begin
                if (legal) begin
                    acc_row <= row_q;
                    acc_col <= addr_s;
                    if (!we_s) begin
                        mode <= ACC_EARLY_WR;
                    end else begin
                        mode    <= ACC_READ;
                        dout    <= rd_bit;
                        dout_en <= 1'b1;
                    end
                end else begin
                    order_err <= 1'b1;
                end
            end else if (late_wr) begin
                mode <= ACC_RMW_DONE;
            end
        end
    end

endmodule

// File: rtl/dram_emu.sv
// Top level of the multiplexed-address dynamic memory emulator.
// Assumes all pin inputs are asynchronous to clk; they share a common
// synchronizer delay so address and data stay aligned with the strobes.
module dram_emu
    import dram_emu_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_en,
    output logic              order_err
);

    logic [STB_W-1:0]  stb_raw;
    logic [STB_W-1:0]  stb_s;
    logic [STB_W-1:0]  stb_fall;
    logic [ADDR_W:0]   dat_s;
    logic [ADDR_W-1:0] rd_row;
    logic [ADDR_W-1:0] rd_col;
    logic              rd_bit;
    logic              ref_en;
    logic [ADDR_W-1:0] ref_row;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_row;
    logic [ADDR_W-1:0] wr_col;
    logic              wr_bit;

    always_comb begin
        stb_raw          = '1;
        stb_raw[STB_RAS] = ras_n;
        stb_raw[STB_CAS] = cas_n;
        stb_raw[STB_WE]  = we_n;
    end

    dram_sync #(.W(STB_W), .RST_VAL('1)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s)
    );

    dram_sync #(.W(ADDR_W + 1), .RST_VAL('0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d({din, addr}), .q(dat_s)
    );

    dram_edge #(.W(STB_W), .RST_VAL('1)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(stb_s), .fall(stb_fall)
    );

    dram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ras_s(stb_s[STB_RAS]), .cas_s(stb_s[STB_CAS]), .we_s(stb_s[STB_WE]),
        .ras_fall(stb_fall[STB_RAS]), .cas_fall(stb_fall[STB_CAS]),
        .we_fall(stb_fall[STB_WE]),
        .addr_s(dat_s[ADDR_W-1:0]), .din_s(dat_s[ADDR_W]),
        .rd_bit(rd_bit), .rd_row(rd_row), .rd_col(rd_col),
        .ref_en(ref_en), .ref_row(ref_row),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_bit(wr_bit),
        .dout(dout), .dout_en(dout_en), .order_err(order_err)
    );

    dram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk),
        .rd_row(rd_row), .rd_col(rd_col), .rd_bit(rd_bit),
        .ref_en(ref_en), .ref_row(ref_row),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_bit(wr_bit)
    );

endmodule

// File: rtl/dram_emu_chk.sv
// Pin-level temporal checks for dram_emu. Input-to-output latency is three
// sampled cycles: two synchronizer stages plus the output register.
module dram_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dout,
    input logic dout_en,
    input logic order_err
);

    // R4
    cas_high_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cas_n, 3) |-> !dout_en);

    // R2
    early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(we_n, 3));

    // R3
    open_on_cas_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> (!$past(cas_n, 3) && $past(cas_n, 4)));

    // R8
    held_output_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(dout_en)) |-> $stable(dout));

    // R10
    open_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> (!$past(ras_n, 3) && !$past(ras_n, 4)));

    // R10
    order_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(order_err) |-> order_err);

endmodule

bind dram_emu dram_emu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dout(dout), .dout_en(dout_en), .order_err(order_err)
);

// File: tb/sim_dram_emu.sv
module sim_dram_emu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic [6:0] addr = '0;
    logic       din = 1'b0;
    logic       dout;
    logic       dout_en;
    logic       order_err;

    int total = 0;
    int fails = 0;
    logic [127:0] model [128];

    always #4 clk = ~clk;

    dram_emu #(.ADDR_W(7)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .order_err(order_err)
    );

    function automatic logic pat(input int r, input int c);
        return 1'(((r * 5 + c * 3) >> 1) & 1);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic ras_open(input logic [6:0] r);
        addr = r; ras_n = 1'b0; tick(4);
    endtask

    task automatic ras_close();
        ras_n = 1'b1; tick(4);
    endtask

    task automatic page_write(input logic [6:0] c, input logic b);
        addr = c; din = b; we_n = 1'b0; cas_n = 1'b0; tick(4);
        chk("R2 early write keeps output off", dout_en, 1'b0);
        cas_n = 1'b1; we_n = 1'b1; tick(4);
    endtask

    task automatic page_read(input string tag, input logic [6:0] c, input logic exp);
        addr = c; we_n = 1'b1; cas_n = 1'b0; tick(4);
        chk({tag, " data"}, dout, exp);
        chk({tag, " enable"}, dout_en, 1'b1);
        cas_n = 1'b1; tick(4);
        chk("R4 output released", dout_en, 1'b0);
    endtask

    task automatic fill_row(input int r);
        ras_open(7'(r));
        for (int c = 0; c < 128; c++) begin
            model[r][c] = pat(r, c);
            page_write(7'(c), model[r][c]);
        end
        ras_close();
    endtask

    task automatic read_row(input string tag, input int r);
        ras_open(7'(r));
        for (int c = 0; c < 128; c++) page_read(tag, 7'(c), model[r][c]);
        ras_close();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic held;
        tick(5);
        chk("R1 reset enable", dout_en, 1'b0);
        chk("R1 reset flag", order_err, 1'b0);
        rst_n = 1'b1; tick(4);

        // R7 R11: page-mode sweeps over edge and middle rows, asymmetric pattern
        for (int i = 0; i < 8; i++) begin
            int rr [8] = '{0, 1, 42, 63, 64, 85, 126, 127};
            fill_row(rr[i]);
        end
        for (int i = 0; i < 8; i++) begin
            int rr [8] = '{0, 1, 42, 63, 64, 85, 126, 127};
            read_row("R7 R11 page readback", rr[i]);
        end

        // R5: single early write changes one bit only
        ras_open(7'd64);
        model[64][17] = ~model[64][17];
        page_write(7'd17, model[64][17]);
        ras_close();
        read_row("R5 target row", 64);
        read_row("R5 neighbour row", 63);

        // R6: row-only refresh cycles
        for (int k = 0; k < 4; k++) begin
            ras_open(k[0] ? 7'd85 : 7'd0);
            chk("R6 refresh output off", dout_en, 1'b0);
            ras_close();
        end
        read_row("R6 row after refresh", 0);
        read_row("R6 other row after refresh", 85);

        // R8: hidden refresh under a held read
        ras_open(7'd1);
        addr = 7'd10; cas_n = 1'b0; tick(4);
        chk("R8 initial read", dout, model[1][10]);
        for (int k = 0; k < 3; k++) begin
            ras_n = 1'b1; tick(4);
            addr = 7'(100 + k); ras_n = 1'b0; tick(4);
            chk("R8 held data", dout, model[1][10]);
            chk("R8 held enable", dout_en, 1'b1);
        end
        ras_n = 1'b1; cas_n = 1'b1; tick(4);
        chk("R4 release after hidden refresh", dout_en, 1'b0);
        read_row("R8 row intact", 1);

        // R9: read-modify-write
        ras_open(7'd127);
        addr = 7'd33; cas_n = 1'b0; tick(4);
        held = model[127][33];
        chk("R9 read phase", dout, held);
        din = ~held; we_n = 1'b0; tick(4);
        chk("R9 old data held", dout, held);
        chk("R9 enable held", dout_en, 1'b1);
        cas_n = 1'b1; we_n = 1'b1; tick(4);
        ras_close();
        model[127][33] = ~held;
        read_row("R9 modified row", 127);

        // R10: column strobe with row strobe high
        addr = 7'd5; din = ~model[127][5]; we_n = 1'b0; cas_n = 1'b0; tick(4);
        chk("R10 no output", dout_en, 1'b0);
        chk("R10 flag set", order_err, 1'b1);
        cas_n = 1'b1; we_n = 1'b1; tick(4);
        chk("R10 flag sticky", order_err, 1'b1);
        read_row("R10 row untouched", 127);

        // R1: reset clears flag, keeps storage
        rst_n = 1'b0; tick(3);
        chk("R1 flag cleared", order_err, 1'b0);
        chk("R1 enable cleared", dout_en, 1'b0);
        rst_n = 1'b1; tick(4);
        ras_open(7'd42);
        page_read("R1 storage kept", 7'd99, model[42][99]);
        ras_close();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule